// File: doc/BRIEF.md
# Sorted Memory Trace Consistency Checker

This block consumes a stream of memory operations that has already been sorted, first by address and then by timestamp, and checks that the stream describes a consistent memory. One beat carries an address, a timestamp, a write flag, a data value and a one-bit region kind: mutable RAM or write-once ROM. For every accepted beat the checker confirms the ordering against the previous beat. It also checks the value against the rules for that region. The first rule broken is latched as a sticky error flag and a code.

The last accepted address, timestamp and value are always visible on the outputs, so a long trace can be cut into segments. The state one segment ends with is handed to the next one as a seed. Loading a seed makes the checker behave as if that state were the beat just before the next one. Without a seed, the first beat after reset has no predecessor and is judged only by the first-access rules.

Top module: `trace_order_checker`

## Requirements
- R1: After reset, errFlag is 0, errCode is 0, lastValid is 0, addrChanged is 0 and lastAddr, lastStep, lastValue are 0.
- R2: inReady equals the inverse of seedLoad. A beat is accepted on a rising clock edge where inValid and inReady are both 1. From the next cycle, lastAddr, lastStep and lastValue show that beat.
- R3: A beat whose address is below the previous entry's address sets error code 1 (address order).
- R4: A beat with the same address as the previous entry and a timestamp less than or equal to it sets error code 2 (timestamp order).
- R5: A read (inWrite=0) with the same address as the previous entry whose value differs from the previous entry's value sets error code 3 (read mismatch).
- R6: In RAM (inRegion=0), a read that is the first access to an address and carries a nonzero value sets error code 4 (uninitialised RAM not zero).
- R7: In ROM (inRegion=1), a read that is the first access to an address sets error code 5 (ROM not initialised by a write).
- R8: In ROM, a write to the same address as the previous entry sets error code 6 (ROM rewrite). A RAM write to the same address is legal.
- R9: addrChanged is registered with each accepted beat. It is 1 when that beat had no predecessor or its address differed from the predecessor, and 0 otherwise.
- R10: errFlag, once set, stays set until reset. errCode keeps the first code. Beats are still accepted and still update lastAddr, lastStep and lastValue.
- R11: A cycle with seedLoad=1 loads seedAddr, seedStep and seedValue into the last-state outputs, sets lastValid to 1 and clears addrChanged. The next beat is checked against the seed.
- R12: With no predecessor (after reset, no seed), the first beat is exempt from the ordering and same-address rules. Only R6 and R7 apply to it.
- R13: When a beat breaks an ordering rule (R3, R4) and a value rule together, the ordering code is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| seedLoad | input | 1 | Load continuation seed this cycle |
| seedAddr | input | ADDR_W | Seed address |
| seedStep | input | STEP_W | Seed timestamp |
| seedValue | input | DATA_W | Seed value |
| inValid | input | 1 | Beat valid |
| inReady | output | 1 | Beat may be accepted |
| inAddr | input | ADDR_W | Beat address |
| inStep | input | STEP_W | Beat timestamp |
| inWrite | input | 1 | 1 = write, 0 = read |
| inValue | input | DATA_W | Beat value |
| inRegion | input | 1 | 0 = RAM, 1 = ROM |
| errFlag | output | 1 | Sticky error flag |
| errCode | output | 3 | First failing rule code |
| addrChanged | output | 1 | Last accepted beat opened a new address |
| lastValid | output | 1 | A predecessor state exists |
| lastAddr | output | ADDR_W | Outgoing continuation address |
| lastStep | output | STEP_W | Outgoing continuation timestamp |
| lastValue | output | DATA_W | Outgoing continuation value |

## Verification
A seed load and a valid beat can arrive in the same cycle. The bench provokes this by raising seedLoad together with a pending beat. It confirms that the beat is held back while the seed lands, and that it is then accepted and judged against the seed. A second overlap is an ordering violation and a value violation in the same beat. It is judged by the reported code, which must be the ordering one. A behavioural model in the bench predicts every output on every clock, and the bench compares the design against it.

// File: rtl/tchk_pkg.sv
package tchk_pkg;

  typedef enum logic [2:0] {
    ERR_NONE        = 3'd0,
    ERR_ADDR_ORDER  = 3'd1,
    ERR_STEP_ORDER  = 3'd2,
    ERR_READ_DIFF   = 3'd3,
    ERR_RAM_NONZERO = 3'd4,
    ERR_ROM_NO_INIT = 3'd5,
    ERR_ROM_REWRITE = 3'd6
  } err_code_e;

  typedef enum logic {
    REGION_RAM = 1'b0,
    REGION_ROM = 1'b1
  } region_e;

  // Control to datapath strobes
  typedef struct packed {
    logic loadSeed;
    logic takeBeat;
    logic freshAddr;
  } tchk_strobe_t;

  // Datapath to control comparison results
  typedef struct packed {
    logic addrSame;
    logic addrBelow;
    logic stepNotAbove;
    logic valueMatch;
    logic valueZero;
  } tchk_cmp_t;

endpackage

// File: rtl/trace_chk_compare.sv
module trace_chk_compare #(
  parameter int ADDR_W = 64,
  parameter int STEP_W = 64,
  parameter int DATA_W = 64
) (
  input  logic [ADDR_W-1:0] curAddr,
  input  logic [STEP_W-1:0] curStep,
  input  logic [DATA_W-1:0] curValue,
  input  logic [ADDR_W-1:0] prevAddr,
  input  logic [STEP_W-1:0] prevStep,
  input  logic [DATA_W-1:0] prevValue,
  output tchk_pkg::tchk_cmp_t cmpOut
);
  localparam logic [DATA_W-1:0] ZeroValue = '0;

  always_comb begin
    cmpOut.addrSame     = (curAddr == prevAddr);
    cmpOut.addrBelow    = (curAddr < prevAddr);
    cmpOut.stepNotAbove = (curStep <= prevStep);
    cmpOut.valueMatch   = (curValue == prevValue);
    cmpOut.valueZero    = (curValue == ZeroValue);
  end
endmodule

// File: rtl/trace_chk_datapath.sv
module trace_chk_datapath #(
  parameter int ADDR_W = 64,
  parameter int STEP_W = 64,
  parameter int DATA_W = 64
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  tchk_pkg::tchk_strobe_t strobeBus,
  input  logic [ADDR_W-1:0]      seedAddr,
  input  logic [STEP_W-1:0]      seedStep,
  input  logic [DATA_W-1:0]      seedValue,
  input  logic [ADDR_W-1:0]      inAddr,
  input  logic [STEP_W-1:0]      inStep,
  input  logic [DATA_W-1:0]      inValue,
  output logic [ADDR_W-1:0]      lastAddr,
  output logic [STEP_W-1:0]      lastStep,
  output logic [DATA_W-1:0]      lastValue,
  output logic                   addrChanged,
  output tchk_pkg::tchk_cmp_t    cmpBus
);
  logic [ADDR_W-1:0] heldAddr;
  logic [STEP_W-1:0] heldStep;
  logic [DATA_W-1:0] heldValue;
  logic              heldFresh;

  trace_chk_compare #(
    .ADDR_W(ADDR_W), .STEP_W(STEP_W), .DATA_W(DATA_W)
  ) cmp_i (
    .curAddr  (inAddr),
    .curStep  (inStep),
    .curValue (inValue),
    .prevAddr (heldAddr),
    .prevStep (heldStep),
    .prevValue(heldValue),
    .cmpOut   (cmpBus)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldAddr  <= '0;
      heldStep  <= '0;
      heldValue <= '0;
      heldFresh <= 1'b0;
    end else if (strobeBus.loadSeed) begin
      heldAddr  <= seedAddr;
      heldStep  <= seedStep;
      heldValue <= seedValue;
      heldFresh <= 1'b0;
    end else if (strobeBus.takeBeat) begin
      heldAddr  <= inAddr;
      heldStep  <= inStep;
      heldValue <= inValue;
      heldFresh <= strobeBus.freshAddr;
    end
  end

  assign lastAddr    = heldAddr;
  assign lastStep    = heldStep;
  assign lastValue   = heldValue;
  assign addrChanged = heldFresh;
endmodule

// File: rtl/trace_chk_ctrl.sv
module trace_chk_ctrl (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   seedLoad,
  input  logic                   inValid,
  input  logic                   inWrite,
  input  logic                   inRegion,
  input  tchk_pkg::tchk_cmp_t    cmpBus,
  output logic                   inReady,
  output tchk_pkg::tchk_strobe_t strobeBus,
  output logic                   errFlag,
  output logic [2:0]             errCode,
  output logic                   hasPrev
);
  import tchk_pkg::*;

  err_code_e ruleCode;
  logic      isRom;
  logic      newAddr;
  err_code_e codeReg;
  logic      flagReg;
  logic      prevReg;

  assign isRom   = (region_e'(inRegion) == REGION_ROM);
  assign newAddr = !prevReg || !cmpBus.addrSame;
  assign inReady = !seedLoad;

  always_comb begin
    strobeBus.loadSeed  = seedLoad;
    strobeBus.takeBeat  = inValid && !seedLoad;
    strobeBus.freshAddr = newAddr;
  end

  // Rule evaluation: ordering first, then value rules
  always_comb begin
    ruleCode = ERR_NONE;
    if (newAddr) begin
      if (prevReg && cmpBus.addrBelow) begin
        ruleCode = ERR_ADDR_ORDER;
      end else if (!inWrite) begin
        if (isRom)                  ruleCode = ERR_ROM_NO_INIT;
        else if (!cmpBus.valueZero) ruleCode = ERR_RAM_NONZERO;
      end
    end else begin
      if (cmpBus.stepNotAbove) begin
        ruleCode = ERR_STEP_ORDER;
      end else if (inWrite) begin
        if (isRom) ruleCode = ERR_ROM_REWRITE;
      end else if (!cmpBus.valueMatch) begin
        ruleCode = ERR_READ_DIFF;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagReg <= 1'b0;
      codeReg <= ERR_NONE;
      prevReg <= 1'b0;
    end else begin
      if (strobeBus.loadSeed || strobeBus.takeBeat) prevReg <= 1'b1;
      if (strobeBus.takeBeat && !flagReg && ruleCode != ERR_NONE) begin
        flagReg <= 1'b1;
        codeReg <= ruleCode;
      end
    end
  end

  assign errFlag = flagReg;
  assign errCode = codeReg;
  assign hasPrev = prevReg;
endmodule

// File: rtl/trace_order_checker.sv
module trace_order_checker #(
  parameter int ADDR_W = 64,
  parameter int STEP_W = 64,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              seedLoad,
  input  logic [ADDR_W-1:0] seedAddr,
  input  logic [STEP_W-1:0] seedStep,
  input  logic [DATA_W-1:0] seedValue,
  input  logic              inValid,
  output logic              inReady,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [STEP_W-1:0] inStep,
  input  logic              inWrite,
  input  logic [DATA_W-1:0] inValue,
  input  logic              inRegion,
  output logic              errFlag,
  output logic [2:0]        errCode,
  output logic              addrChanged,
  output logic              lastValid,
  output logic [ADDR_W-1:0] lastAddr,
  output logic [STEP_W-1:0] lastStep,
  output logic [DATA_W-1:0] lastValue
);
  tchk_pkg::tchk_strobe_t strobeBus;
  tchk_pkg::tchk_cmp_t    cmpBus;

  trace_chk_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .seedLoad (seedLoad),
    .inValid  (inValid),
    .inWrite  (inWrite),
    .inRegion (inRegion),
    .cmpBus   (cmpBus),
    .inReady  (inReady),
    .strobeBus(strobeBus),
    .errFlag  (errFlag),
    .errCode  (errCode),
    .hasPrev  (lastValid)
  );

  trace_chk_datapath #(
    .ADDR_W(ADDR_W), .STEP_W(STEP_W), .DATA_W(DATA_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobeBus  (strobeBus),
    .seedAddr   (seedAddr),
    .seedStep   (seedStep),
    .seedValue  (seedValue),
    .inAddr     (inAddr),
    .inStep     (inStep),
    .inValue    (inValue),
    .lastAddr   (lastAddr),
    .lastStep   (lastStep),
    .lastValue  (lastValue),
    .addrChanged(addrChanged),
    .cmpBus     (cmpBus)
  );
endmodule

// File: rtl/trace_order_checker_props.sv
module trace_order_checker_props #(
  parameter int ADDR_W = 64,
  parameter int STEP_W = 64,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              seedLoad,
  input logic [ADDR_W-1:0] seedAddr,
  input logic [STEP_W-1:0] seedStep,
  input logic [DATA_W-1:0] seedValue,
  input logic              inValid,
  input logic              inReady,
  input logic [ADDR_W-1:0] inAddr,
  input logic [STEP_W-1:0] inStep,
  input logic              inWrite,
  input logic [DATA_W-1:0] inValue,
  input logic              inRegion,
  input logic              errFlag,
  input logic [2:0]        errCode,
  input logic              addrChanged,
  input logic              lastValid,
  input logic [ADDR_W-1:0] lastAddr,
  input logic [STEP_W-1:0] lastStep,
  input logic [DATA_W-1:0] lastValue
);
  a_r2_capture: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (lastAddr == $past(inAddr) && lastStep == $past(inStep)
                              && lastValue == $past(inValue) && lastValid));

  a_r11_seed: assert property (@(posedge clk) disable iff (!rstN)
    seedLoad |=> (lastAddr == $past(seedAddr) && lastStep == $past(seedStep)
                  && lastValue == $past(seedValue) && lastValid && !addrChanged));

  a_r3_addr_order: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && lastValid && !errFlag && inAddr < lastAddr)
      |=> (errFlag && errCode == 3'd1));

  a_r8_rom_rewrite: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && lastValid && !errFlag && inAddr == lastAddr
     && inStep > lastStep && inWrite && inRegion) |=> (errFlag && errCode == 3'd6));

  a_r9_first_is_new: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && !lastValid) |=> addrChanged);

  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> (errFlag && $stable(errCode)));

  a_r10_code_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (errCode != 3'd0));
endmodule

bind trace_order_checker trace_order_checker_props #(
  .ADDR_W(ADDR_W), .STEP_W(STEP_W), .DATA_W(DATA_W)
) chk_i (.*);

// File: tb/trace_order_checker_tb_top.sv
`timescale 1ns/1ps
module trace_order_checker_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        seedLoad = 1'b0;
  logic [63:0] seedAddr = '0, seedStep = '0, seedValue = '0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [63:0] inAddr = '0, inStep = '0, inValue = '0;
  logic        inWrite = 1'b0, inRegion = 1'b0;
  logic        errFlag, addrChanged, lastValid;
  logic [2:0]  errCode;
  logic [63:0] lastAddr, lastStep, lastValue;

  int checks = 0;
  int failures = 0;
  bit doneFlag = 0;

  always #2.5 clk = ~clk;

  trace_order_checker dut_i (
    .clk(clk), .rstN(rstN), .seedLoad(seedLoad), .seedAddr(seedAddr),
    .seedStep(seedStep), .seedValue(seedValue), .inValid(inValid),
    .inReady(inReady), .inAddr(inAddr), .inStep(inStep), .inWrite(inWrite),
    .inValue(inValue), .inRegion(inRegion), .errFlag(errFlag),
    .errCode(errCode), .addrChanged(addrChanged), .lastValid(lastValid),
    .lastAddr(lastAddr), .lastStep(lastStep), .lastValue(lastValue)
  );

  // Behavioural reference model
  bit          mHas, mErr, mChg;
  int          mCode;
  logic [63:0] mAddr, mStep, mVal;

  function automatic int judge(logic [63:0] a, logic [63:0] s, logic wr,
                               logic [63:0] v, logic rom);
    bit sameAddr;
    sameAddr = mHas && (a == mAddr);
    if (mHas && a < mAddr) return 1;
    if (sameAddr && s <= mStep) return 2;
    if (sameAddr) begin
      if (wr) return rom ? 6 : 0;
      return (v != mVal) ? 3 : 0;
    end
    if (!wr && rom) return 5;
    if (!wr && v != 0) return 4;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mHas = 0; mErr = 0; mChg = 0; mCode = 0; mAddr = 0; mStep = 0; mVal = 0;
    end else if (seedLoad) begin
      mAddr = seedAddr; mStep = seedStep; mVal = seedValue; mHas = 1; mChg = 0;
    end else if (inValid) begin
      int c;
      c = judge(inAddr, inStep, inWrite, inValue, inRegion);
      mChg = !mHas || (inAddr != mAddr);
      if (c != 0 && !mErr) begin mErr = 1; mCode = c; end
      mAddr = inAddr; mStep = inStep; mVal = inValue; mHas = 1;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Every-cycle comparison, sampled away from the edge
  always begin
    @(posedge clk);
    #2;
    if (rstN && !doneFlag) begin
      check(lastAddr == mAddr, "R2", "lastAddr", lastAddr, mAddr);
      check(lastStep == mStep, "R2", "lastStep", lastStep, mStep);
      check(lastValue == mVal, "R2", "lastValue", lastValue, mVal);
      check(inReady == !seedLoad, "R2", "inReady", inReady, !seedLoad);
      check(lastValid == mHas, "R11", "lastValid", lastValid, mHas);
      check(addrChanged == mChg, "R9", "addrChanged", addrChanged, mChg);
      check(errFlag == mErr, "R10", "errFlag", errFlag, mErr);
      check(errCode == 3'(mCode), "R13", "errCode", errCode, mCode);
    end
  end

  task automatic endRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    endRun();
  end

  task automatic doReset();
    @(negedge clk);
    rstN = 0; inValid = 0; seedLoad = 0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1;
  endtask

  task automatic beat(input logic [63:0] a, input logic [63:0] s, input logic wr,
                      input logic [63:0] v, input logic rom);
    @(negedge clk);
    inValid = 1; inAddr = a; inStep = s; inWrite = wr; inValue = v; inRegion = rom;
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 0; seedLoad = 0;
  endtask

  task automatic expectCode(input int code, input string tag);
    check(errFlag == (code != 0), tag, "errFlag", errFlag, code != 0);
    check(errCode == 3'(code), tag, "errCode", errCode, code);
  endtask

  initial begin
    // R1 reset state
    doReset();
    check(errFlag == 0 && errCode == 0, "R1", "error state", {errFlag, errCode}, 0);
    check(lastValid == 0 && addrChanged == 0, "R1", "valid/changed", {lastValid, addrChanged}, 0);
    check(lastAddr == 0 && lastStep == 0 && lastValue == 0, "R1", "last state", lastAddr, 0);
    check(inReady == 1, "R1", "inReady", inReady, 1);

    // Clean mixed trace; R2 R9 R12
    beat(64'hA000, 24, 1, 42, 0);
    beat(64'hA000, 25, 0, 42, 0);
    beat(64'hA008, 21, 0, 0, 0);
    beat(64'hA008, 26, 0, 0, 0);
    beat(64'hA010, 3, 1, 5, 0);
    beat(64'hA010, 9, 1, 6, 0);
    beat(64'hA010, 10, 0, 6, 0);
    beat(64'h8000_0000, 1, 1, 7, 1);
    beat(64'h8000_0000, 2, 0, 7, 1);
    idle();
    expectCode(0, "R2");
    check(lastAddr == 64'h8000_0000 && lastValue == 7, "R2", "final beat", lastAddr, 64'h8000_0000);
    check(addrChanged == 0, "R9", "same address read", addrChanged, 0);

    // R12 first beat exempt: address 0, step 0
    doReset();
    beat(0, 0, 1, 64'hFF, 0);
    idle();
    expectCode(0, "R12");
    check(addrChanged == 1, "R9", "first beat new", addrChanged, 1);

    // R3 address order
    doReset();
    beat(64'h200, 1, 1, 1, 0);
    beat(64'h100, 2, 1, 1, 0);
    idle();
    expectCode(1, "R3");

    // R4 equal timestamp
    doReset();
    beat(64'h200, 5, 1, 1, 0);
    beat(64'h200, 5, 0, 1, 0);
    idle();
    expectCode(2, "R4");

    // R5 read mismatch after write
    doReset();
    beat(64'h300, 5, 1, 11, 0);
    beat(64'h300, 6, 0, 12, 0);
    idle();
    expectCode(3, "R5");

    // R6 RAM first read nonzero at a new address
    doReset();
    beat(64'h300, 5, 1, 11, 0);
    beat(64'h308, 2, 0, 3, 0);
    idle();
    expectCode(4, "R6");

    // R7 ROM first read
    doReset();
    beat(64'h8000_0010, 4, 0, 0, 1);
    idle();
    expectCode(7 - 2, "R7");

    // R8 ROM rewrite; RAM rewrite legal first
    doReset();
    beat(64'h40, 1, 1, 1, 0);
    beat(64'h40, 2, 1, 2, 0);
    beat(64'h8000_0000, 3, 1, 9, 1);
    beat(64'h8000_0000, 4, 1, 9, 1);
    idle();
    expectCode(6, "R8");

    // R10 sticky: mismatch then descending address
    doReset();
    beat(64'h500, 1, 1, 1, 0);
    beat(64'h500, 2, 0, 2, 0);
    beat(64'h100, 3, 1, 4, 0);
    idle();
    expectCode(3, "R10");
    check(lastAddr == 64'h100 && lastValue == 4, "R10", "state after error", lastAddr, 64'h100);

    // R11 seed collides with a pending beat
    doReset();
    @(negedge clk);
    seedLoad = 1; seedAddr = 64'h100; seedStep = 50; seedValue = 9;
    inValid = 1; inAddr = 64'h100; inStep = 60; inWrite = 0; inValue = 9; inRegion = 0;
    #1;
    check(inReady == 0, "R2", "ready during seed", inReady, 0);
    @(negedge clk);
    check(lastAddr == 64'h100 && lastStep == 50, "R11", "seed loaded", lastStep, 50);
    check(lastValid == 1 && addrChanged == 0, "R11", "seed flags", {lastValid, addrChanged}, 2);
    seedLoad = 0;
    idle();
    check(lastStep == 60, "R11", "held beat taken", lastStep, 60);
    expectCode(0, "R11");

    // R11 seed value enforced on next read
    doReset();
    @(negedge clk);
    seedLoad = 1; seedAddr = 64'h700; seedStep = 8; seedValue = 3;
    idle();
    beat(64'h700, 9, 0, 4, 0);
    idle();
    expectCode(3, "R11");

    // R13 ordering beats value: lower step and wrong value
    doReset();
    beat(64'h600, 10, 1, 1, 0);
    beat(64'h600, 4, 0, 2, 0);
    idle();
    expectCode(2, "R13");

    idle();
    endRun();
  end
endmodule